// File: doc/BRIEF.md
# Reset Source and CPU Clock-Switch Controller

This block is part of the system-control logic of a small microcontroller. It collects three reset sources: an asynchronous active-low power-on reset, a one-cycle watchdog underflow pulse and an oscillation-stop detect flag for the main clock. Two configuration bits decide whether the watchdog and oscillation-stop events reset the system or are ignored. When a reset is taken, the block drives a system reset pulse of fixed length and records the cause. After release it either requests a restart from the reset vector or, after an oscillation-stop reset, holds the system halted. While a partial (non power-on) reset is applied, it publishes a mask of registers that keep their contents.

The block also owns the CPU clock-source selection and the divide-by-8 setting. It accepts a switch request only when the target source reports stable oscillation. A move from the on-chip oscillator to the main clock is accepted only when divide-by-8 is already selected, so the CPU lands in medium-speed mode. A rejected request raises a sticky error flag that software clears by writing 1.

Top module: `rst_clk_guard`

## Requirements
- R1: While `porN` is low and for the first 3 rising edges after it rises, `sysRst` is 1. On the 4th edge `sysRst` drops and `restartReq` is 1 for exactly one cycle. Power-on reset clears `rstCause` to 00, `procMode` to 00, `clkSel`, `div8`, `swErr`, `wdtIrq` and `halted`.
- R2: With `wdtRstEn`=1 and the block running, a `wdtUnderflow` sampled at an edge raises `sysRst` after that edge and holds it for 4 cycles. `rstCause` becomes 01, and `restartReq` pulses for one cycle after release.
- R3: With `wdtRstEn`=0, an underflow causes no reset and sets `wdtIrq`. `irqClr`=1 clears it.
- R4: With `oscStopSel`=0, `oscStopDet` causes a 4-cycle reset with `rstCause`=10. After release `halted` is 1 and no `restartReq` is given. While halted, reset events, writes and clock requests are ignored until power-on reset.
- R5: With `oscStopSel`=1, `oscStopDet` has no effect.
- R6: A watchdog or oscillation-stop reset keeps `procMode`. It returns `clkSel` to 0, and `div8`, `swErr` and `wdtIrq` to 0.
- R7: `keepMask` equals `PRESERVE_MASK` while a watchdog or oscillation-stop reset is applied. It is 0 during power-on reset and whenever `sysRst` is 0.
- R8: A switch request (`swReq`, target `swTarget`: 0 on-chip oscillator, 1 main clock) is rejected unless the target's stable flag (`ocoStable` or `mainStable`) is 1. A rejection sets `swErr` and leaves `clkSel` unchanged.
- R9: A request from `clkSel`=0 to target 1 is rejected unless `div8` is already 1. After an accepted switch of this kind, `clkSel`=1 and `div8`=1.
- R10: `swErr` is sticky and `errClr`=1 clears it. A rejection in the same cycle as a clear leaves it set.
- R11: If watchdog and oscillation-stop resets fire in the same cycle, the oscillation-stop reset wins (`rstCause`=10, halt). Events that arrive while `sysRst` is 1 are ignored.
- R12: A switch from the main clock back to the on-chip oscillator is accepted when `ocoStable`=1. A stable target makes `clkSel` follow `swTarget` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| wdtUnderflow | input | 1 | Watchdog underflow pulse |
| oscStopDet | input | 1 | Main-clock oscillation stop detected |
| wdtRstEn | input | 1 | 1: underflow resets; 0: underflow sets interrupt flag |
| oscStopSel | input | 1 | 0: oscillation stop resets; 1: ignored |
| irqClr | input | 1 | Write-1 clear of `wdtIrq` |
| modeWe | input | 1 | Processor-mode write strobe |
| modeIn | input | 2 | Processor-mode write data |
| divWe | input | 1 | Divide-by-8 write strobe |
| divIn | input | 1 | Divide-by-8 write data |
| swReq | input | 1 | Clock-source switch request |
| swTarget | input | 1 | Requested source: 0 on-chip oscillator, 1 main clock |
| mainStable | input | 1 | Main clock oscillating stably |
| ocoStable | input | 1 | On-chip oscillator oscillating stably |
| errClr | input | 1 | Write-1 clear of `swErr` |
| sysRst | output | 1 | System reset, active high |
| restartReq | output | 1 | One-cycle request to fetch the reset vector |
| halted | output | 1 | System held halted after oscillation-stop reset |
| rstCause | output | 2 | Last reset cause: 00 power-on, 01 watchdog, 10 oscillation stop |
| keepMask | output | NUM_SFR | Registers excluded from reinitialization during this reset |
| procMode | output | 2 | Processor-mode field |
| clkSel | output | 1 | CPU clock source: 0 on-chip oscillator, 1 main clock |
| div8 | output | 1 | Divide-by-8 selected |
| swErr | output | 1 | Sticky clock-switch rejection flag |
| wdtIrq | output | 1 | Watchdog interrupt request flag |

## Verification
A wrong count in the reset sequencer shows on `sysRst` within four cycles of a trigger, as a pulse that is too short or too long, or as a missing or misplaced `restartReq`. A wrong cause or halt decision shows on `rstCause` and `halted` at the first sample after the reset is released. Errors in the clock guard show at the next edge after a request: `clkSel` moves when it must not, or `swErr` fails to rise. A mode field that is wrongly cleared shows on `procMode` as soon as a partial reset is released.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_WDT = 2'b01,
    CAUSE_OSC = 2'b10
  } rst_cause_e;

  typedef enum logic {
    SRC_OCO  = 1'b0,
    SRC_MAIN = 1'b1
  } clk_src_e;

  // strobes from the reset control to the register datapath
  typedef struct packed {
    logic sfrInit;    // partial reset applied this edge
    logic run;        // not in reset and not halted
    logic wdtIrqSet;  // underflow with reset disabled
  } ctl_strobe_t;
endpackage

// File: rtl/rcg_ctrl.sv
module rcg_ctrl
  import rcg_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int NUM_SFR = 8,
  parameter logic [NUM_SFR-1:0] PRESERVE_MASK = '1
) (
  input  logic clk,
  input  logic porN,
  input  logic wdtUnderflow,
  input  logic oscStopDet,
  input  logic wdtRstEn,
  input  logic oscStopSel,
  output logic sysRst,
  output logic restartReq,
  output logic halted,
  output logic [1:0] rstCause,
  output logic [NUM_SFR-1:0] keepMask,
  output ctl_strobe_t strobe
);
  localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic running, wdtHit, oscHit;

  assign running = !sysRst && !halted;
  assign wdtHit  = running && wdtUnderflow && wdtRstEn;
  assign oscHit  = running && oscStopDet && !oscStopSel;

  assign strobe.sfrInit   = wdtHit || oscHit;
  assign strobe.run       = running;
  assign strobe.wdtIrqSet = running && wdtUnderflow && !wdtRstEn;

  assign keepMask = (sysRst && rstCause != CAUSE_POR) ? PRESERVE_MASK : '0;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sysRst     <= 1'b1;
      cnt        <= CNT_LOAD;
      rstCause   <= CAUSE_POR;
      halted     <= 1'b0;
      restartReq <= 1'b0;
    end else begin
      restartReq <= 1'b0;
      if (sysRst) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          sysRst <= 1'b0;
          if (rstCause == CAUSE_OSC) halted <= 1'b1;
          else restartReq <= 1'b1;
        end
      end else if (oscHit || wdtHit) begin
        sysRst   <= 1'b1;
        cnt      <= CNT_LOAD;
        rstCause <= oscHit ? CAUSE_OSC : CAUSE_WDT;  // R11 priority
      end
    end
  end

  a_r2_rst_hold: assert property (@(posedge clk) disable iff (!porN)
    (sysRst && cnt != '0) |=> sysRst);
  a_r1_restart_at_release: assert property (@(posedge clk) disable iff (!porN)
    restartReq |-> (!sysRst && $past(sysRst)));
  a_r4_halt_no_restart: assert property (@(posedge clk) disable iff (!porN)
    halted |-> !restartReq);
  a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!porN)
    (sysRst && cnt != '0) |=> $stable(rstCause));
endmodule

// File: rtl/rcg_datapath.sv
module rcg_datapath
  import rcg_pkg::*;
(
  input  logic clk,
  input  logic porN,
  input  ctl_strobe_t strobe,
  input  logic irqClr,
  input  logic modeWe,
  input  logic [1:0] modeIn,
  input  logic divWe,
  input  logic divIn,
  input  logic swReq,
  input  logic swTarget,
  input  logic mainStable,
  input  logic ocoStable,
  input  logic errClr,
  output logic [1:0] procMode,
  output logic clkSel,
  output logic div8,
  output logic swErr,
  output logic wdtIrq
);
  logic targetStable, divOk, accept, reject;

  assign targetStable = (swTarget == SRC_MAIN) ? mainStable : ocoStable;
  assign divOk  = !(clkSel == SRC_OCO && swTarget == SRC_MAIN) || div8;
  assign accept = strobe.run && swReq && targetStable && divOk;
  assign reject = strobe.run && swReq && !(targetStable && divOk);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      procMode <= 2'b00;
      clkSel   <= SRC_OCO;
      div8     <= 1'b0;
      swErr    <= 1'b0;
      wdtIrq   <= 1'b0;
    end else if (strobe.sfrInit) begin
      clkSel <= SRC_OCO;
      div8   <= 1'b0;
      swErr  <= 1'b0;
      wdtIrq <= 1'b0;
    end else if (strobe.run) begin
      if (modeWe) procMode <= modeIn;
      if (divWe) div8 <= divIn;
      if (accept) begin
        clkSel <= swTarget;
        if (clkSel == SRC_OCO && swTarget == SRC_MAIN) div8 <= 1'b1;
      end
      if (reject) swErr <= 1'b1;
      else if (errClr) swErr <= 1'b0;
      if (strobe.wdtIrqSet) wdtIrq <= 1'b1;
      else if (irqClr) wdtIrq <= 1'b0;
    end
  end

  a_r6_mode_kept: assert property (@(posedge clk) disable iff (!porN)
    strobe.sfrInit |=> $stable(procMode));
  a_r9_div8_before_main: assert property (@(posedge clk) disable iff (!porN)
    (clkSel && !$past(clkSel)) |-> ($past(div8) && div8));
  a_r8_stable_target: assert property (@(posedge clk) disable iff (!porN)
    (clkSel != $past(clkSel) && !$past(strobe.sfrInit))
      |-> $past(swTarget ? mainStable : ocoStable));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!porN)
    (swErr && !errClr && !strobe.sfrInit) |=> swErr);
endmodule

// File: rtl/rst_clk_guard.sv
module rst_clk_guard
  import rcg_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int NUM_SFR = 8,
  parameter logic [NUM_SFR-1:0] PRESERVE_MASK = 8'b0100_0110
) (
  input  logic clk,
  input  logic porN,
  input  logic wdtUnderflow,
  input  logic oscStopDet,
  input  logic wdtRstEn,
  input  logic oscStopSel,
  input  logic irqClr,
  input  logic modeWe,
  input  logic [1:0] modeIn,
  input  logic divWe,
  input  logic divIn,
  input  logic swReq,
  input  logic swTarget,
  input  logic mainStable,
  input  logic ocoStable,
  input  logic errClr,
  output logic sysRst,
  output logic restartReq,
  output logic halted,
  output logic [1:0] rstCause,
  output logic [NUM_SFR-1:0] keepMask,
  output logic [1:0] procMode,
  output logic clkSel,
  output logic div8,
  output logic swErr,
  output logic wdtIrq
);
  ctl_strobe_t strobe;

  rcg_ctrl #(.RST_CYCLES(RST_CYCLES), .NUM_SFR(NUM_SFR), .PRESERVE_MASK(PRESERVE_MASK)) uCtrl (
    .clk(clk), .porN(porN), .wdtUnderflow(wdtUnderflow), .oscStopDet(oscStopDet),
    .wdtRstEn(wdtRstEn), .oscStopSel(oscStopSel), .sysRst(sysRst),
    .restartReq(restartReq), .halted(halted), .rstCause(rstCause),
    .keepMask(keepMask), .strobe(strobe)
  );

  rcg_datapath uData (
    .clk(clk), .porN(porN), .strobe(strobe), .irqClr(irqClr),
    .modeWe(modeWe), .modeIn(modeIn), .divWe(divWe), .divIn(divIn),
    .swReq(swReq), .swTarget(swTarget), .mainStable(mainStable),
    .ocoStable(ocoStable), .errClr(errClr), .procMode(procMode),
    .clkSel(clkSel), .div8(div8), .swErr(swErr), .wdtIrq(wdtIrq)
  );
endmodule

// File: tb/tb_rst_clk_guard.sv
`timescale 1ns/1ps
module tb_rst_clk_guard;
  localparam logic [7:0] KEEP = 8'b0100_0110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic porN = 1'b0, wdtUnderflow = 1'b0, oscStopDet = 1'b0;
  logic wdtRstEn = 1'b1, oscStopSel = 1'b0, irqClr = 1'b0;
  logic modeWe = 1'b0, divWe = 1'b0, divIn = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic swReq = 1'b0, swTarget = 1'b0, mainStable = 1'b0, ocoStable = 1'b1, errClr = 1'b0;
  logic sysRst, restartReq, halted, clkSel, div8, swErr, wdtIrq;
  logic [1:0] rstCause, procMode;
  logic [7:0] keepMask;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  rst_clk_guard dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // caller stands at the negedge just after the trigger edge
  task automatic expectPulse(input string req, input bit restart, input int mask);
    chk({req, " rst start"}, sysRst, 1);
    chk({req, " mask"}, keepMask, mask);
    repeat (3) begin
      @(negedge clk);
      chk({req, " rst held"}, sysRst, 1);
    end
    @(negedge clk);
    chk({req, " rst released"}, sysRst, 0);
    chk({req, " restart"}, restartReq, restart);
    chk({req, " halted"}, halted, !restart);
    @(negedge clk);
    chk({req, " restart one cycle"}, restartReq, 0);
  endtask

  task automatic fire(input bit w, input bit o);
    @(negedge clk); wdtUnderflow = w; oscStopDet = o;
    @(negedge clk); wdtUnderflow = 0; oscStopDet = 0;
  endtask

  task automatic request(input bit tgt);
    @(negedge clk); swReq = 1; swTarget = tgt;
    @(negedge clk); swReq = 0;
  endtask

  task automatic testPor();
    porN = 0;
    repeat (2) @(negedge clk);
    chk("R1 por cause", rstCause, 0);
    chk("R1 por mode", procMode, 0);
    chk("R1 por clkSel", clkSel, 0);
    chk("R7 por mask zero", keepMask, 0);
    porN = 1;
    expectPulse("R1", 1, 0);
  endtask

  task automatic testClock();
    mainStable = 1;
    request(1);
    chk("R9 no div8 clkSel", clkSel, 0);
    chk("R9 no div8 err", swErr, 1);
    @(negedge clk); errClr = 1; swReq = 1; swTarget = 1;
    @(negedge clk); swReq = 0;
    chk("R10 reject beats clear", swErr, 1);
    @(negedge clk); errClr = 0;
    chk("R10 cleared", swErr, 0);
    divWe = 1; divIn = 1;
    @(negedge clk); divWe = 0; mainStable = 0;
    request(1);
    chk("R8 unstable clkSel", clkSel, 0);
    chk("R8 unstable err", swErr, 1);
    @(negedge clk); errClr = 1;
    @(negedge clk); errClr = 0; mainStable = 1;
    request(1);
    chk("R9 switch clkSel", clkSel, 1);
    chk("R9 medium speed", div8, 1);
    chk("R9 no err", swErr, 0);
    ocoStable = 0;
    request(0);
    chk("R8 oco unstable", clkSel, 1);
    @(negedge clk); errClr = 1; ocoStable = 1;
    @(negedge clk); errClr = 0;
    request(0);
    chk("R12 back to oco", clkSel, 0);
    request(1);
    chk("R12 main again", clkSel, 1);
  endtask

  task automatic testWdtReset();
    @(negedge clk); modeWe = 1; modeIn = 2'b10; errClr = 0;
    @(negedge clk); modeWe = 0;
    wdtRstEn = 1;
    fire(1, 0);
    chk("R2 cause", rstCause, 1);
    @(negedge clk); wdtUnderflow = 1;  // during reset: ignored
    @(negedge clk); wdtUnderflow = 0;
    chk("R11 no retrigger", sysRst, 1);
    chk("R6 clkSel init", clkSel, 0);
    chk("R6 div8 init", div8, 0);
    chk("R6 mode kept", procMode, 2);
    @(negedge clk); @(negedge clk);
    chk("R2 release at 4", sysRst, 0);
    chk("R2 restart", restartReq, 1);
    chk("R7 mask after", keepMask, 0);
    @(negedge clk);
    chk("R2 restart one cycle", restartReq, 0);
  endtask

  task automatic testWdtIrq();
    wdtRstEn = 0;
    fire(1, 0);
    chk("R3 no reset", sysRst, 0);
    chk("R3 irq set", wdtIrq, 1);
    chk("R3 cause unchanged", rstCause, 1);
    irqClr = 1;
    @(negedge clk); irqClr = 0;
    chk("R3 irq cleared", wdtIrq, 0);
  endtask

  task automatic testOscIgnored();
    oscStopSel = 1;
    fire(0, 1);
    chk("R5 no reset", sysRst, 0);
    chk("R5 not halted", halted, 0);
    chk("R5 mode", procMode, 2);
  endtask

  task automatic testOscHalt();
    oscStopSel = 0; wdtRstEn = 1;
    fire(1, 1);
    chk("R11 osc wins", rstCause, 2);
    expectPulse("R4", 0, KEEP);
    chk("R6 mode kept osc", procMode, 2);
    fire(1, 0);
    chk("R4 halted ignores wdt", sysRst, 0);
    request(0);
    chk("R4 halted ignores switch", swErr, 0);
    chk("R4 still halted", halted, 1);
  endtask

  initial begin
    testPor();
    testClock();
    testWdtReset();
    testWdtIrq();
    testOscIgnored();
    testOscHalt();
    testPor();
    chk("R1 halt cleared", halted, 0);
    chk("R1 mode cleared", procMode, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule